// File: doc/BRIEF.md
# I2C Host Serial Clock Waveform Generator

This block produces the serial clock of an I2C host. The clock has a low phase and a high phase, and each phase length is programmed through one 32-bit configuration register. That register holds a low divider, a high divider, a power-of-two prescale exponent, a clock-source select and a data-hold field. The phases can be timed from the system clock, which adds a fixed three-cycle overhead to each phase. They can also be timed from an alternate rate source, which reaches the block as a one-cycle enable pulse and adds no overhead. When the input filter is on, each phase grows by the filter threshold plus one system cycle.

After each SCL falling edge the block raises a strobe that marks the moment the data line may change. Outside high-speed mode this strobe comes a programmed number of cycles after the edge. In high-speed mode it comes on the edge itself. The byte engine of the host uses the falling-edge strobe and the data-change strobe to move SDA.

Top module: `scl_wavegen`

## Requirements
- R1: After reset the configuration register reads 0, `scl_o` is 1, and both strobes are 0.
- R2: A write with `wr_prot_i` = 1 leaves the configuration register unchanged. A write with `wr_prot_i` = 0 stores the data.
- R3: Register fields: bits 28:24 hold, bit 20 source (0 = system clock, 1 = alternate ticks), bits 18:16 exponent, bits 15:8 high divider, bits 7:0 low divider. All other bits read 0.
- R4: With source 0 and the filter off, the low phase lasts lowdiv·2^exp + 3 cycles and the high phase lasts highdiv·2^exp + 3 cycles. `scl_fall_o` pulses in the first cycle of each low phase.
- R5: With source 1 and the filter off, a phase lasts until div·2^exp alternate ticks have been counted. The phase ends in the cycle of the last tick.
- R6: With the filter on, each phase gets (threshold + 1) more system cycles, for either source.
- R7: A phase whose computed length is zero lasts one cycle.
- R8: With `hs_mode_i` = 0, `sda_upd_o` pulses hold + 3 cycles after the cycle in which `scl_fall_o` pulses.
- R9: With `hs_mode_i` = 1, `sda_upd_o` pulses in the same cycle as `scl_fall_o`.
- R10: While `host_en_i` is 0 and the generator is idle, `scl_o` stays 1 and no strobes are produced. Enabling the block starts a low phase.
- R11: A divider written during a phase takes effect from the next phase boundary.
- R12: Dropping `host_en_i` lets the current phase run to its full length. SCL then returns high and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| wr_prot_i | input | 1 | Write-protect enable |
| cfg_rdata_o | output | 32 | Configuration register contents |
| host_en_i | input | 1 | Host mode enable |
| hs_mode_i | input | 1 | High-speed mode select |
| alt_tick_i | input | 1 | Alternate rate source, one-cycle enable |
| filt_en_i | input | 1 | Input filter enable |
| filt_thres_i | input | THR_W | Filter threshold |
| scl_o | output | 1 | Serial clock level |
| scl_fall_o | output | 1 | Pulses in the first low cycle |
| sda_upd_o | output | 1 | Data may change |

## Verification
The hardest case to reach is the alternate-source phase that mixes tick counting with the filter's extra system cycles, together with the zero-length fallback. Both need a tick pattern in which the phase end falls on a tick cycle. The bench drives the ticks both every cycle and every other cycle. It counts how many ticks fall inside each low phase. It also sweeps every small divider, exponent and filter combination for both sources. A divider rewrite in the middle of a phase and an enable drop in the middle of a phase are forced at fixed cycle offsets after a detected falling edge.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef struct packed {
    logic [2:0] rsv_hi;
    logic [4:0] hold;
    logic [2:0] rsv_mid;
    logic       src_alt;
    logic       rsv_lo;
    logic [2:0] exp;
    logic [7:0] hi_div;
    logic [7:0] lo_div;
  } scl_cfg_t;

  localparam logic [31:0] CfgMask = 32'h1F17_FFFF;
  localparam int unsigned PhaseOvh = 3;
  localparam int unsigned HoldOvh  = 3;
endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
  import scl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        prot_i,
  output scl_cfg_t    cfg_o
);
  scl_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cfg_q <= '0;
    else if (we_i && !prot_i) cfg_q <= scl_cfg_t'(wdata_i & CfgMask);
  end

  assign cfg_o = cfg_q;

  assert_wr_prot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_i |=> $stable(cfg_q));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned EXP_W = 3,
  parameter int unsigned THR_W = 8,
  localparam int unsigned CNT_W = DIV_W + (2**EXP_W) - 1 + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] lo_div_i,
  input  logic [DIV_W-1:0] hi_div_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             src_alt_i,
  input  logic             tick_i,
  input  logic             filt_en_i,
  input  logic [THR_W-1:0] thres_i,
  output logic             scl_o,
  output logic             fall_o
);
  logic             run_q, scl_q, fall_q;
  logic [CNT_W-1:0] ticks_q, cyc_q;
  logic [CNT_W-1:0] base, extra, ld_ticks, ld_cyc;
  logic [DIV_W-1:0] div_sel;
  logic             nxt_lvl, phase_end;

  // level of the phase about to be loaded
  assign nxt_lvl = run_q ? ~scl_q : 1'b0;
  assign div_sel = nxt_lvl ? hi_div_i : lo_div_i;

  always_comb begin
    base     = CNT_W'(div_sel) << exp_i;
    extra    = filt_en_i ? CNT_W'(thres_i) + CNT_W'(1) : '0;
    ld_ticks = src_alt_i ? base : '0;
    ld_cyc   = (src_alt_i ? '0 : base + CNT_W'(PhaseOvh)) + extra;
    if (ld_ticks == '0 && ld_cyc == '0) ld_cyc = CNT_W'(1);
  end

  assign phase_end = run_q &&
    ((ticks_q == '0 && cyc_q == CNT_W'(1)) ||
     (ticks_q == CNT_W'(1) && tick_i && cyc_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      scl_q   <= 1'b1;
      fall_q  <= 1'b0;
      ticks_q <= '0;
      cyc_q   <= '0;
    end else begin
      fall_q <= 1'b0;
      if (!run_q) begin
        if (en_i) begin
          run_q   <= 1'b1;
          scl_q   <= 1'b0;
          fall_q  <= 1'b1;
          ticks_q <= ld_ticks;
          cyc_q   <= ld_cyc;
        end
      end else if (phase_end) begin
        if (en_i) begin
          scl_q   <= ~scl_q;
          fall_q  <= scl_q;
          ticks_q <= ld_ticks;
          cyc_q   <= ld_cyc;
        end else begin
          run_q   <= 1'b0;
          scl_q   <= 1'b1;
          ticks_q <= '0;
          cyc_q   <= '0;
        end
      end else if (ticks_q != '0) begin
        if (tick_i) ticks_q <= ticks_q - CNT_W'(1);
      end else begin
        cyc_q <= cyc_q - CNT_W'(1);
      end
    end
  end

  assign scl_o  = scl_q;
  assign fall_o = fall_q;

  assert_no_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (ticks_q != '0 || cyc_q != '0));
  assert_idle_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> scl_q && !fall_q);
endmodule

// File: rtl/scl_hold_timer.sv
module scl_hold_timer
  import scl_pkg::*;
#(
  parameter int unsigned HOLD_W = 5,
  localparam int unsigned HC_W = HOLD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hs_i,
  input  logic              fall_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              fire_o
);
  logic [HC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (fall_i && !hs_i) cnt_q <= HC_W'(hold_i) + HC_W'(HoldOvh);
    else if (cnt_q != '0)     cnt_q <= cnt_q - HC_W'(1);
  end

  assign fire_o = (cnt_q == HC_W'(1));

  assert_fire_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !fall_i |=> !fire_o);
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_pkg::*;
#(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             wr_prot_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic             host_en_i,
  input  logic             hs_mode_i,
  input  logic             alt_tick_i,
  input  logic             filt_en_i,
  input  logic [THR_W-1:0] filt_thres_i,
  output logic             scl_o,
  output logic             scl_fall_o,
  output logic             sda_upd_o
);
  scl_cfg_t cfg;
  logic     fall, hold_fire;

  scl_cfg_reg u_cfg (
    .clk_i, .rst_ni,
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .prot_i  (wr_prot_i),
    .cfg_o   (cfg)
  );

  scl_phase_gen #(.DIV_W(8), .EXP_W(3), .THR_W(THR_W)) u_phase (
    .clk_i, .rst_ni,
    .en_i      (host_en_i),
    .lo_div_i  (cfg.lo_div),
    .hi_div_i  (cfg.hi_div),
    .exp_i     (cfg.exp),
    .src_alt_i (cfg.src_alt),
    .tick_i    (alt_tick_i),
    .filt_en_i (filt_en_i),
    .thres_i   (filt_thres_i),
    .scl_o     (scl_o),
    .fall_o    (fall)
  );

  scl_hold_timer #(.HOLD_W(5)) u_hold (
    .clk_i, .rst_ni,
    .en_i   (host_en_i),
    .hs_i   (hs_mode_i),
    .fall_i (fall),
    .hold_i (cfg.hold),
    .fire_o (hold_fire)
  );

  assign cfg_rdata_o = 32'(cfg);
  assign scl_fall_o  = fall;
  assign sda_upd_o   = host_en_i && (hs_mode_i ? fall : hold_fire);

  assert_fall_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |-> !scl_o && $past(scl_o));
  assert_hs_sda_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_en_i && hs_mode_i && scl_fall_o |-> sda_upd_o);
  assert_stay_high_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_en_i && scl_o |=> scl_o);
endmodule

// File: tb/scl_wavegen_tb.sv
module scl_wavegen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, prot = 1'b0, en = 1'b0, hs = 1'b0, tick = 1'b1, filt = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  thres = '0;
  logic [31:0] rdata;
  logic        scl, fall, sda;
  int          n_chk = 0, n_fail = 0;
  bit          tick_alt = 1'b0;

  always #10 clk = ~clk;

  scl_wavegen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .wr_prot_i(prot), .cfg_rdata_o(rdata), .host_en_i(en), .hs_mode_i(hs),
    .alt_tick_i(tick), .filt_en_i(filt), .filt_thres_i(thres),
    .scl_o(scl), .scl_fall_o(fall), .sda_upd_o(sda)
  );

  always begin
    @(posedge clk); #2;
    tick = tick_alt ? ~tick : 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int hold, input int src, input int ex,
                                     input int hi, input int lo);
    return (32'(hold) << 24) | (32'(src) << 20) | (32'(ex) << 16) | (32'(hi) << 8) | 32'(lo);
  endfunction

  // waits for a falling edge; measures low, high, sda delay, ticks in low
  task automatic measure(output int lo, output int hi, output int sdly,
                         output int tks, output bit fall_ok);
    int guard = 0;
    lo = 0; hi = 0; sdly = -1; tks = 0; fall_ok = 1'b0;
    while (scl !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    fall_ok = (fall === 1'b1);
    for (int k = 0; k < 5000; k++) begin
      if (scl === 1'b0 && hi == 0) begin lo++; if (tick) tks++; end
      else if (scl === 1'b1) hi++;
      else break;
      if (sda === 1'b1 && sdly < 0) sdly = k;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lo, hi, sd, tk;
    bit fo;
    repeat (3) @(negedge clk);
    check(rdata == 32'h0, "R1 reg", int'(rdata), 0);
    check(scl == 1'b1 && !fall && !sda, "R1 outputs", int'({scl, fall, sda}), 4);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 field mask
    wr(32'hFFFF_FFFF);
    check(rdata == 32'h1F17_FFFF, "R3 mask", int'(rdata), 32'h1F17_FFFF);
    // R2 write protect
    wr(32'h0000_0505);
    prot = 1'b1;
    wr(32'h0000_0A0A);
    check(rdata == 32'h0000_0505, "R2 blocked", int'(rdata), 32'h505);
    prot = 1'b0;
    wr(32'h0000_0A0A);
    check(rdata == 32'h0000_0A0A, "R2 unblocked", int'(rdata), 32'hA0A);

    // R10 idle: no clock while disabled
    begin
      int bad = 0;
      repeat (50) begin @(negedge clk); if (!scl || fall || sda) bad++; end
      check(bad == 0, "R10 idle", bad, 0);
    end

    // R4 R5 R6 R7 sweep
    for (int src = 0; src < 2; src++)
      for (int fm = 0; fm < 3; fm++)
        for (int ex = 0; ex < 3; ex++)
          for (int ld = 0; ld < 4; ld++)
            for (int hd = 0; hd < 4; hd++) begin
              int ext, el, eh;
              en = 1'b0;
              repeat (60) @(negedge clk);
              filt = (fm != 0);
              thres = (fm == 2) ? 8'd2 : 8'd0;
              ext = (fm == 0) ? 0 : int'(thres) + 1;
              wr(mk(0, src, ex, hd, ld));
              el = ld * (1 << ex) + (src == 0 ? 3 : 0) + ext;
              eh = hd * (1 << ex) + (src == 0 ? 3 : 0) + ext;
              if (el == 0) el = 1;
              if (eh == 0) eh = 1;
              en = 1'b1;
              measure(lo, hi, sd, tk, fo);
              check(fo, "R10 start fall", int'(fo), 1);
              if (src == 0) begin
                check(lo == el, fm ? "R6 sys low" : "R4 sys low", lo, el);
                check(hi == eh, fm ? "R6 sys high" : "R4 sys high", hi, eh);
              end else begin
                check(lo == el, (el == 1 && ext == 0) ? "R7 alt low" : (fm ? "R6 alt low" : "R5 alt low"), lo, el);
                check(hi == eh, (eh == 1 && ext == 0) ? "R7 alt high" : (fm ? "R6 alt high" : "R5 alt high"), hi, eh);
              end
            end
    en = 1'b0; filt = 1'b0; thres = '0;
    repeat (60) @(negedge clk);

    // R5 sparse ticks: ticks inside the low phase equal div*2^exp
    tick_alt = 1'b1;
    wr(mk(0, 1, 1, 2, 3));
    en = 1'b1;
    measure(lo, hi, sd, tk, fo);
    check(tk == 6, "R5 tick count", tk, 6);
    check(lo >= 11 && lo <= 12, "R5 sparse low", lo, 11);
    en = 1'b0; tick_alt = 1'b0;
    repeat (80) @(negedge clk);

    // R8 / R9 hold sweep
    for (int h = 0; h < 32; h++)
      for (int m = 0; m < 2; m++) begin
        en = 1'b0;
        repeat (60) @(negedge clk);
        hs = m[0];
        wr(mk(h, 0, 0, 20, 20));
        en = 1'b1;
        measure(lo, hi, sd, tk, fo);
        if (m == 0) check(sd == h + 3, "R8 hold", sd, h + 3);
        else        check(sd == 0, "R9 hs", sd, 0);
      end
    en = 1'b0; hs = 1'b0;
    repeat (80) @(negedge clk);

    // R11 divider change mid phase
    wr(mk(0, 0, 0, 1, 20));
    en = 1'b1;
    while (scl !== 1'b0) @(negedge clk);
    begin
      int l1 = 0, h1 = 0;
      for (int k = 0; k < 200; k++) begin
        if (k == 3) begin we = 1'b1; wdata = mk(0, 0, 0, 1, 2); end
        if (k == 4) we = 1'b0;
        if (scl === 1'b0 && h1 == 0) l1++;
        else if (scl === 1'b1) h1++;
        else break;
        @(negedge clk);
      end
      check(l1 == 23, "R11 current low kept", l1, 23);
      check(h1 == 4, "R11 high", h1, 4);
      measure(lo, hi, sd, tk, fo);
      check(lo == 5, "R11 next low", lo, 5);
    end
    en = 1'b0;
    repeat (60) @(negedge clk);

    // R12 disable mid low phase
    wr(mk(0, 0, 0, 20, 20));
    en = 1'b1;
    while (scl !== 1'b0) @(negedge clk);
    begin
      int l2 = 0, bad = 0;
      for (int k = 0; k < 200; k++) begin
        if (k == 5) en = 1'b0;
        if (scl === 1'b0) l2++; else break;
        @(negedge clk);
      end
      check(l2 == 23, "R12 phase finished", l2, 23);
      repeat (100) begin @(negedge clk); if (!scl || fall || sda) bad++; end
      check(bad == 0, "R12 stays high", bad, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule